// File: doc/BRIEF.md
# Table-Branch Sequencer

This block carries out a 16-bit table-jump instruction. The halfword table sits in memory right after the instruction. A general register holds an index into that table. The block reads the signed halfword entry that the index selects, and then points the program counter at an offset from the instruction's successor. That offset is twice the entry's value. The instruction's successor is also the table base. Both the index and the loaded entry are doubled, because they count halfwords and not bytes.

A pipeline controller pulses `start` with the instruction word and the current PC. The sequencer then steps through five named states:

- `ST_IDLE` waits for a recognised start and moves to `ST_CALC`.
- `ST_CALC` reads the index register and forms the table address, then moves to `ST_READ`.
- `ST_READ` issues a one-cycle halfword read, then moves to `ST_WAIT`.
- `ST_WAIT` captures the returned entry, then moves to `ST_UPDATE`.
- `ST_UPDATE` presents the new PC with a load strobe and a done strobe, then returns to `ST_IDLE`.

Every transition other than the one out of `ST_IDLE` is unconditional. The operation does not touch the condition flags, and the block has no flag outputs.

The memory port has a fixed latency of one cycle: data requested in one cycle must be on `mem_data` during the next cycle. The register port is combinational: `reg_data` must reflect `reg_sel` within the same cycle.

Top module: `tbr_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `busy`, `mem_rd`, `pc_load` and `done` are all 0.
- R2: A start is accepted only in `ST_IDLE` when instruction bits 15:5 equal 11'b00000000010. Any other word is ignored: `busy`, `mem_rd` and `pc_load` stay 0.
- R3: In the cycle after an accepted start (`ST_CALC`), `reg_sel` equals instruction bits 4:0.
- R4: In the second cycle after an accepted start (`ST_READ`), `mem_rd` is 1 for exactly one cycle. In that cycle `mem_addr` = (PC + 2) + (index register << 1), modulo 2^32.
- R5: `pc_next` = (PC + 2) + (sign-extended 16-bit entry << 1), modulo 2^32.
- R6: `pc_load` and `done` pulse together for one cycle, in the fourth cycle after the start edge, so the PC loads on the fifth clock counting the start edge. `busy` is 1 from the cycle after start through that pulse.
- R7: A start while `busy` is 1 is ignored. The running operation completes with its original result, and no second operation follows.
- R8: Bit 0 of `pc_next` is 0 whenever `pc_load` is 1.
- R9: The state order is `ST_IDLE`, `ST_CALC`, `ST_READ`, `ST_WAIT`, `ST_UPDATE`, and then back to `ST_IDLE`, with `busy` 0 in the cycle after the update.
- R10: The instruction and PC are captured at the accepted start. Changes to `instr` and `pc_in` afterwards do not alter `reg_sel`, `mem_addr` or `pc_next`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to execute `instr` |
| instr | input | 16 | Instruction word |
| pc_in | input | 32 | Address of the instruction |
| reg_sel | output | 5 | Index register number |
| reg_data | input | 32 | Value of the selected register, same cycle |
| mem_rd | output | 1 | Halfword read request |
| mem_addr | output | 32 | Table entry byte address |
| mem_data | input | 16 | Read data, valid the cycle after `mem_rd` |
| pc_load | output | 1 | Load `pc_next` into the PC |
| pc_next | output | 32 | Branch target |
| done | output | 1 | Operation complete strobe |
| busy | output | 1 | Sequencer not idle |

## Verification
The hardest situation to reach from the ports is a second valid start arriving mid-sequence while `instr` and `pc_in` change at the same time. A flawed design would then either restart or pick up the new operands in its later arithmetic. The random loop raises `start` again, with a fresh opcode-matching word and a different PC, on a random subset of operations during the `ST_CALC` to `ST_WAIT` cycles. Directed cases cover the extreme entries 0x8000 and 0x7FFF, a PC near the top of the address space, and index registers 0 and 31.

// File: rtl/tbr_pkg.sv
package tbr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CALC,
        ST_READ,
        ST_WAIT,
        ST_UPDATE
    } tbr_state_e;

    // Upper bits of the table-jump opcode; the low field is the index register.
    localparam logic [10:0] JUMP_OPC = 11'b00000000010;

    // Byte length of the instruction; the table starts right after it.
    localparam int unsigned INSTR_BYTES = 2;

endpackage

// File: rtl/tbr_decode.sv
module tbr_decode #(
    parameter int INSTR_W = 16,
    parameter int IDX_W   = 5,
    parameter logic [INSTR_W-IDX_W-1:0] OPC = tbr_pkg::JUMP_OPC
) (
    input  logic [INSTR_W-1:0] instr,
    output logic               hit,
    output logic [IDX_W-1:0]   idx
);
    always_comb begin
        hit = (instr[INSTR_W-1:IDX_W] == OPC);
        idx = instr[IDX_W-1:0];
    end
endmodule

// File: rtl/tbr_agen.sv
module tbr_agen #(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int ENTRY_W = 16
) (
    input  logic [ADDR_W-1:0]  base,
    input  logic [DATA_W-1:0]  index_val,
    input  logic [ENTRY_W-1:0] entry,
    output logic [ADDR_W-1:0]  tab_addr,
    output logic [ADDR_W-1:0]  target
);
    localparam int EXT_W = ADDR_W - ENTRY_W;

    logic [ADDR_W-1:0] idx_ext;
    logic [ADDR_W-1:0] ent_ext;

    always_comb begin
        idx_ext  = ADDR_W'(index_val);
        ent_ext  = {{EXT_W{entry[ENTRY_W-1]}}, entry};
        tab_addr = base + (idx_ext << 1);
        target   = base + (ent_ext << 1);
    end
endmodule

// File: rtl/tbr_seq.sv
module tbr_seq #(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int ENTRY_W = 16,
    parameter int INSTR_W = 16,
    parameter int IDX_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [INSTR_W-1:0] instr,
    input  logic [ADDR_W-1:0]  pc_in,
    output logic [IDX_W-1:0]   reg_sel,
    input  logic [DATA_W-1:0]  reg_data,
    output logic               mem_rd,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic [ENTRY_W-1:0] mem_data,
    output logic               pc_load,
    output logic [ADDR_W-1:0]  pc_next,
    output logic               done,
    output logic               busy
);
    import tbr_pkg::*;

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSTR_BYTES);

    tbr_state_e state, state_nx;

    logic               dec_hit;
    logic [IDX_W-1:0]   dec_idx;
    logic [IDX_W-1:0]   idx_q;
    logic [ADDR_W-1:0]  base_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [ENTRY_W-1:0] entry_q;
    logic [ADDR_W-1:0]  tab_addr;
    logic [ADDR_W-1:0]  target;

    tbr_decode #(
        .INSTR_W (INSTR_W),
        .IDX_W   (IDX_W)
    ) u_decode (
        .instr (instr),
        .hit   (dec_hit),
        .idx   (dec_idx)
    );

    tbr_agen #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .ENTRY_W (ENTRY_W)
    ) u_agen (
        .base      (base_q),
        .index_val (reg_data),
        .entry     (entry_q),
        .tab_addr  (tab_addr),
        .target    (target)
    );

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start && dec_hit) state_nx = ST_CALC;
            ST_CALC:   state_nx = ST_READ;
            ST_READ:   state_nx = ST_WAIT;
            ST_WAIT:   state_nx = ST_UPDATE;
            ST_UPDATE: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Datapath captures, one per state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= '0;
            base_q  <= '0;
            addr_q  <= '0;
            entry_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start && dec_hit) begin
                    idx_q  <= dec_idx;
                    base_q <= pc_in + STEP;
                end
                ST_CALC:   addr_q  <= tab_addr;
                ST_WAIT:   entry_q <= mem_data;
                default:   ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        reg_sel  = idx_q;
        mem_addr = addr_q;
        pc_next  = target;
        mem_rd   = 1'b0;
        pc_load  = 1'b0;
        done     = 1'b0;
        busy     = 1'b1;
        unique case (state)
            ST_IDLE:   busy = 1'b0;
            ST_READ:   mem_rd = 1'b1;
            ST_UPDATE: begin
                pc_load = 1'b1;
                done    = 1'b1;
            end
            default:   ;
        endcase
    end

endmodule

// File: rtl/tbr_seq_chk.sv
module tbr_seq_chk #(
    parameter int ADDR_W = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start,
    input logic                 busy,
    input logic                 mem_rd,
    input logic                 pc_load,
    input logic                 done,
    input logic [ADDR_W-1:0]    pc_next,
    input tbr_pkg::tbr_state_e  state
);
    import tbr_pkg::*;

    AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd); // R4
    AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> !pc_load); // R6
    AST_LOAD_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> $past(mem_rd, 2)); // R6
    AST_DONE_WITH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pc_load && busy)); // R6
    AST_PC_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> !pc_next[0]); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd && !pc_load)); // R2
    AST_CALC_TO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CALC) |=> (state == ST_READ)); // R9
    AST_UPDATE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_UPDATE) |=> (state == ST_IDLE)); // R9
    AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && state != ST_UPDATE) |=> (state != ST_CALC)); // R7
endmodule

bind tbr_seq tbr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .mem_rd  (mem_rd),
    .pc_load (pc_load),
    .done    (done),
    .pc_next (pc_next),
    .state   (state)
);

// File: tb/tb_tbr_seq.sv
module tb_tbr_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] instr = '0;
    logic [31:0] pc_in = '0;
    logic [4:0]  reg_sel;
    logic [31:0] reg_data;
    logic        mem_rd;
    logic [31:0] mem_addr;
    logic [15:0] mem_data = 16'h5A5A;
    logic        pc_load;
    logic [31:0] pc_next;
    logic        done;
    logic        busy;

    logic [31:0] rf [32];
    logic [15:0] entry_val = '0;
    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    tbr_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .pc_in(pc_in),
        .reg_sel(reg_sel), .reg_data(reg_data), .mem_rd(mem_rd),
        .mem_addr(mem_addr), .mem_data(mem_data), .pc_load(pc_load),
        .pc_next(pc_next), .done(done), .busy(busy)
    );

    assign reg_data = rf[reg_sel];

    // Memory model: one-cycle latency, junk when not read
    always @(posedge clk) begin
        if (mem_rd) mem_data <= entry_val;
        else        mem_data <= 16'hDEAD;
    end

    function automatic logic [31:0] exp_tab(input logic [31:0] pc, input logic [31:0] r);
        return pc + 32'd2 + (r << 1);
    endfunction

    function automatic logic [31:0] exp_tgt(input logic [31:0] pc, input logic [15:0] e);
        logic [31:0] se;
        se = {{16{e[15]}}, e};
        return pc + 32'd2 + (se << 1);
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One table jump; inject=1 raises start again mid-sequence with new operands
    task automatic run_op(input logic [4:0] idx, input logic [31:0] pc,
                          input logic [31:0] rv, input logic [15:0] ent, input bit inject);
        logic [31:0] et, eg;
        rf[idx]   = rv;
        entry_val = ent;
        et = exp_tab(pc, rv);
        eg = exp_tgt(pc, ent);
        @(negedge clk);
        start = 1'b1;
        instr = {11'b00000000010, idx};
        pc_in = pc;
        @(negedge clk);                       // ST_CALC
        start = inject;
        instr = {11'b00000000010, ~idx};      // R10 operands change
        pc_in = pc ^ 32'h0F0F_0F00;
        check(reg_sel == idx, "R3 reg_sel", 32'(reg_sel), 32'(idx));
        check(busy && !mem_rd && !pc_load, "R6 busy in calc", {29'd0, busy, mem_rd, pc_load}, 32'd4);
        @(negedge clk);                       // ST_READ
        check(mem_rd == 1'b1, "R4 mem_rd", 32'(mem_rd), 32'd1);
        check(mem_addr == et, "R4 table address", mem_addr, et);
        @(negedge clk);                       // ST_WAIT
        check(!mem_rd && !pc_load, "R9 wait state", {30'd0, mem_rd, pc_load}, 32'd0);
        @(negedge clk);                       // ST_UPDATE
        start = 1'b0;
        check(pc_load && done, "R6 load strobe", {30'd0, pc_load, done}, 32'd3);
        check(pc_next == eg, inject ? "R7 R10 target" : "R5 target", pc_next, eg);
        check(pc_next[0] == 1'b0, "R8 even pc", 32'(pc_next[0]), 32'd0);
        @(negedge clk);                       // back in ST_IDLE
        check(!busy && !pc_load && !mem_rd, "R9 R7 idle after", {29'd0, busy, pc_load, mem_rd}, 32'd0);
    endtask

    task automatic try_ignored(input logic [15:0] w);
        bit seen;
        seen = 1'b0;
        @(negedge clk);
        start = 1'b1;
        instr = w;
        pc_in = 32'h0000_1000;
        @(negedge clk);
        start = 1'b0;
        check(!busy, "R2 no accept", 32'(busy), 32'd0);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            if (mem_rd || pc_load || busy) seen = 1'b1;
        end
        check(!seen, "R2 no activity", 32'(seen), 32'd0);
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL R6 watchdog: actual hang expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h7AB1_E5E7));
        for (int i = 0; i < 32; i++) rf[i] = 32'(i) * 32'h0101_0101;
        repeat (3) @(negedge clk);
        check(!busy && !mem_rd && !pc_load && !done, "R1 in reset",
              {28'd0, busy, mem_rd, pc_load, done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !mem_rd && !pc_load && !done, "R1 after reset",
              {28'd0, busy, mem_rd, pc_load, done}, 32'd0);

        // Directed corners
        run_op(5'd0,  32'h0000_0100, 32'd0,        16'h0000, 1'b0);
        run_op(5'd31, 32'h0000_2000, 32'd7,        16'h8000, 1'b0);
        run_op(5'd3,  32'h0000_4000, 32'd1,        16'h7FFF, 1'b0);
        run_op(5'd9,  32'hFFFF_FFFE, 32'h0000_0010, 16'hFFFF, 1'b0);
        run_op(5'd12, 32'h1234_5670, 32'hFFFF_FFFF, 16'h0001, 1'b1);
        try_ignored(16'h0000);
        try_ignored(16'h0060);
        try_ignored(16'h8045);
        try_ignored(16'h0020);

        // Constrained random
        for (int n = 0; n < 40; n++) begin
            logic [4:0]  ri;
            logic [31:0] rp;
            ri = 5'($urandom);
            rp = $urandom & 32'hFFFF_FFFE;
            run_op(ri, rp, $urandom, 16'($urandom), 1'($urandom));
            if ((n % 8) == 0) try_ignored(16'($urandom) | 16'h0400);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule